// File: doc/BRIEF.md
# Dual-Threshold Temperature Alarm with Interrupt Control

The block watches one signed temperature reading in Q8.7 fixed point, which has 7 fraction bits and spans roughly -256 to +255 degrees. Two independent alarms are derived from it. The normal alarm (TEMP) and the higher-severity over-temperature alarm (OT) each have an upper and a lower threshold. Each alarm runs either in hysteresis mode, with a set point and a re-arm point, or in window mode, where it fires whenever the reading leaves the band. A new reading is taken only on a valid strobe.

Alarm outcomes feed a status register together with grouped supply comparator flags. Each supply flag can be enabled per channel. A status bit only records that its source was active. It does not say which threshold of the pair was crossed. Status bits are cleared by writing 1s. A mask register, where 1 means masked, is changed through separate enable and disable write addresses. The interrupt output is level-sensitive. Software reaches all registers through a simple synchronous write port with a combinational read.

Top module: `thermal_alarm_unit`

## Requirements
- R1: After reset, MODE=0x3, MASK=0x3FF, STATUS=0, SUPEN=0, TEMP upper/lower = 85/75 degrees (0x2A80/0x2580), OT upper/lower = 110/100 degrees (0x3700/0x3200), and irq is 0.
- R2: The reading is a signed Q8.7 value captured only when meas_valid is high. Both alarms are re-evaluated at that clock edge and at no other. The status register follows one clock later. All comparisons are signed.
- R3: In hysteresis mode an inactive alarm becomes active when the reading is greater than or equal to its upper threshold.
- R4: In hysteresis mode an active alarm stays active until a reading strictly below its lower threshold. After that it needs the upper threshold again to re-arm.
- R5: In window mode an alarm is active exactly when the last reading is above its upper threshold or below its lower threshold. The bounds themselves count as inside.
- R6: MODE bit 0 set selects hysteresis for OT, and MODE bit 1 set selects hysteresis for TEMP. A cleared bit selects window mode.
- R7: STATUS bit 9 is TEMP, bit 8 is OT, and bits 0 to 4 are supply groups 0 to 4. Bits 5 to 7 read 0.
- R8: A status bit is set whenever its source is active. Writing 1 to STATUS clears that bit. If the source is still active in the same cycle, the bit stays 1.
- R9: Supply channel k of group g is sup_cmp bit g*4+k, enabled by SUPEN bit g*4+k. A group's source is active while any enabled channel of it is in alarm.
- R10: MASK bit 1 means masked. Writing 1s to ENABLE clears the matching MASK bits. Writing 1s to DISABLE sets them.
- R11: irq is 1 exactly when some STATUS bit is set whose MASK bit is 0.
- R12: Register addresses: 0 MODE, 1 TEMP upper, 2 TEMP lower, 3 OT upper, 4 OT lower, 5 STATUS, 6 MASK, 7 ENABLE, 8 DISABLE, 9 SUPEN. Thresholds read zero-extended in bits 15:0. ENABLE, DISABLE and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| meas_valid | input | 1 | Strobe that captures a new reading |
| meas_value | input | 16 | Signed Q8.7 temperature reading |
| sup_cmp | input | 20 | Supply comparator flags, 4 channels per group |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Level-sensitive interrupt |

## Verification
Two things can land on a status bit in the same clock: a write-1-to-clear from software and a source that is still active. The bench provokes this by writing STATUS while an alarm is held in its hysteresis band, or while it is outside its window. It then expects the bit to read back as 1. Once the reading has moved past the re-arm point, the same write must leave 0. A second overlap comes from mode changes: a MODE write between readings changes how the next strobe is judged, and never the current state. The bench therefore sets alarms up in one mode and reads them in the other.

// File: rtl/tau_pkg.sv
package tau_pkg;
  typedef logic signed [15:0] temp_t;

  localparam int ST_W     = 10;
  localparam int OT_BIT   = 8;
  localparam int TEMP_BIT = 9;

  localparam logic [3:0] A_MODE  = 4'd0;
  localparam logic [3:0] A_TUP   = 4'd1;
  localparam logic [3:0] A_TLO   = 4'd2;
  localparam logic [3:0] A_OUP   = 4'd3;
  localparam logic [3:0] A_OLO   = 4'd4;
  localparam logic [3:0] A_STAT  = 4'd5;
  localparam logic [3:0] A_MASK  = 4'd6;
  localparam logic [3:0] A_EN    = 4'd7;
  localparam logic [3:0] A_DIS   = 4'd8;
  localparam logic [3:0] A_SUPEN = 4'd9;

  // hysteresis step: set at or above upper, release strictly below lower
  function automatic logic hyst_step(logic act, temp_t v, temp_t up, temp_t lo);
    if (!act) return (v >= up);
    else      return !(v < lo);
  endfunction

  // window: outside the closed band [lo, up]
  function automatic logic win_out(temp_t v, temp_t up, temp_t lo);
    return (v > up) || (v < lo);
  endfunction
endpackage

// File: rtl/tau_cmp.sv
module tau_cmp
  import tau_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  strobe,
  input  temp_t value,
  input  temp_t upper,
  input  temp_t lower,
  input  logic  hyst_mode,
  output logic  active
);
  logic next_act;

  always_comb begin
    if (hyst_mode) next_act = hyst_step(active, value, upper, lower);
    else           next_act = win_out(value, upper, lower);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      active <= 1'b0;
    else if (strobe) active <= next_act;
  end
endmodule

// File: rtl/tau_supply.sv
module tau_supply #(
  parameter int NGRP = 5,
  parameter int GCH  = 4
) (
  input  logic [NGRP*GCH-1:0] cmp,
  input  logic [NGRP*GCH-1:0] en,
  output logic [NGRP-1:0]     grp
);
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp[g] = |(cmp[g*GCH +: GCH] & en[g*GCH +: GCH]);
  end
endmodule

// File: rtl/tau_irq.sv
module tau_irq #(
  parameter int SW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] src,
  input  logic [SW-1:0] clr,
  input  logic [SW-1:0] en_set,
  input  logic [SW-1:0] dis_set,
  output logic [SW-1:0] status,
  output logic [SW-1:0] mask,
  output logic          irq
);
  logic [SW-1:0] pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= '1;
    end else begin
      status <= (status & ~clr) | src;
      mask   <= (mask | dis_set) & ~en_set;
    end
  end

  assign pending = status & ~mask;
  assign irq     = |pending;
endmodule

// File: rtl/thermal_alarm_unit.sv
module thermal_alarm_unit
  import tau_pkg::*;
#(
  parameter int NGRP = 5,
  parameter int GCH  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                meas_valid,
  input  logic [15:0]         meas_value,
  input  logic [NGRP*GCH-1:0] sup_cmp,
  input  logic                reg_wr,
  input  logic [3:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic                irq
);
  localparam int SUPW = NGRP * GCH;

  logic [1:0]    mode_q;
  temp_t         t_up, t_lo, o_up, o_lo;
  logic [SUPW-1:0] supen_q;
  logic          temp_act, ot_act;
  logic [NGRP-1:0] sup_grp;
  logic [ST_W-1:0] src, clr, en_set, dis_set, status, mask;

  // register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 2'b11;
      t_up    <= 16'sh2A80;
      t_lo    <= 16'sh2580;
      o_up    <= 16'sh3700;
      o_lo    <= 16'sh3200;
      supen_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_MODE:  mode_q  <= reg_wdata[1:0];
        A_TUP:   t_up    <= reg_wdata[15:0];
        A_TLO:   t_lo    <= reg_wdata[15:0];
        A_OUP:   o_up    <= reg_wdata[15:0];
        A_OLO:   o_lo    <= reg_wdata[15:0];
        A_SUPEN: supen_q <= reg_wdata[SUPW-1:0];
        default: ;
      endcase
    end
  end

  tau_cmp u_ot (
    .clk(clk), .rst_n(rst_n), .strobe(meas_valid), .value(meas_value),
    .upper(o_up), .lower(o_lo), .hyst_mode(mode_q[0]), .active(ot_act)
  );

  tau_cmp u_temp (
    .clk(clk), .rst_n(rst_n), .strobe(meas_valid), .value(meas_value),
    .upper(t_up), .lower(t_lo), .hyst_mode(mode_q[1]), .active(temp_act)
  );

  tau_supply #(.NGRP(NGRP), .GCH(GCH)) u_sup (
    .cmp(sup_cmp), .en(supen_q), .grp(sup_grp)
  );

  always_comb begin
    src = '0;
    src[NGRP-1:0]  = sup_grp;
    src[OT_BIT]    = ot_act;
    src[TEMP_BIT]  = temp_act;
  end

  assign clr     = (reg_wr && reg_addr == A_STAT) ? reg_wdata[ST_W-1:0] : '0;
  assign en_set  = (reg_wr && reg_addr == A_EN)   ? reg_wdata[ST_W-1:0] : '0;
  assign dis_set = (reg_wr && reg_addr == A_DIS)  ? reg_wdata[ST_W-1:0] : '0;

  tau_irq #(.SW(ST_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .src(src), .clr(clr), .en_set(en_set),
    .dis_set(dis_set), .status(status), .mask(mask), .irq(irq)
  );

  // combinational read
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_MODE:  reg_rdata[1:0]      = mode_q;
      A_TUP:   reg_rdata[15:0]     = t_up;
      A_TLO:   reg_rdata[15:0]     = t_lo;
      A_OUP:   reg_rdata[15:0]     = o_up;
      A_OLO:   reg_rdata[15:0]     = o_lo;
      A_STAT:  reg_rdata[ST_W-1:0] = status;
      A_MASK:  reg_rdata[ST_W-1:0] = mask;
      A_SUPEN: reg_rdata[SUPW-1:0] = supen_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/tau_checker.sv
module tau_checker
  import tau_pkg::*;
#(
  parameter int NGRP = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            strobe,
  input temp_t           meas,
  input temp_t           t_up,
  input temp_t           t_lo,
  input temp_t           o_up,
  input temp_t           o_lo,
  input logic [1:0]      mode,
  input logic            temp_act,
  input logic            ot_act,
  input logic [NGRP-1:0] sup_grp,
  input logic [ST_W-1:0] status,
  input logic [ST_W-1:0] mask,
  input logic            wr,
  input logic [3:0]      addr,
  input logic [31:0]     wdata
);
  AST_HYST_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && mode[1] && meas >= t_up) |=> temp_act);  // R3
  AST_HYST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && mode[1] && temp_act && meas >= t_lo) |=> temp_act);  // R4
  AST_WIN_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !mode[0] && (meas > o_up || meas < o_lo)) |=> ot_act);  // R5
  AST_WIN_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !mode[0] && meas <= o_up && meas >= o_lo) |=> !ot_act);  // R5
  AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(temp_act) && $stable(ot_act));  // R2
  AST_LEVEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    temp_act |=> status[TEMP_BIT]);  // R8
  AST_SUP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    sup_grp[0] |=> status[0]);  // R9
  AST_MASK_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_EN && wdata[TEMP_BIT]) |=> !mask[TEMP_BIT]);  // R10
  AST_MASK_DIS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_DIS && wdata[OT_BIT]) |=> mask[OT_BIT]);  // R10
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:5] == 3'b000);  // R7
endmodule

bind thermal_alarm_unit tau_checker #(.NGRP(NGRP)) u_chk (
  .clk(clk), .rst_n(rst_n), .strobe(meas_valid), .meas(meas_value),
  .t_up(t_up), .t_lo(t_lo), .o_up(o_up), .o_lo(o_lo), .mode(mode_q),
  .temp_act(temp_act), .ot_act(ot_act), .sup_grp(sup_grp),
  .status(status), .mask(mask), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata)
);

// File: tb/test_thermal_alarm_unit.sv
module test_thermal_alarm_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        meas_valid = 1'b0;
  logic [15:0] meas_value = '0;
  logic [19:0] sup_cmp = '0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  logic mon_go = 1'b0;
  bit done = 1'b0;

  typedef struct { logic [31:0] exp; bit is_irq; string tag; } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  thermal_alarm_unit i_thermal_alarm_unit (
    .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .meas_value(meas_value),
    .sup_cmp(sup_cmp), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // register indices (R12) and status bits (R7)
  localparam logic [3:0] MODE = 0, TUP = 1, TLO = 2, OUP = 3, OLO = 4,
                         STAT = 5, MASK = 6, EN = 7, DIS = 8, SUPEN = 9;
  localparam logic [31:0] B_T = 32'h200, B_O = 32'h100;

  function automatic logic [15:0] q87(int deg);
    return 16'(deg * 128);
  endfunction

  // monitor: pops expected items, compares away from the rising edge
  always @(negedge clk) begin
    if (mon_go && sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      act = it.is_irq ? {31'b0, irq} : reg_rdata;
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s actual=0x%0h expected=0x%0h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    tick(1);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_wr = 1'b0;
  endtask

  task automatic meas(logic [15:0] v);
    tick(1);
    meas_valid = 1'b1; meas_value = v;
    tick(1);
    meas_valid = 1'b0;
  endtask

  task automatic chk_reg(logic [3:0] a, logic [31:0] e, string tag);
    tick(1);
    reg_addr = a;
    sb.push_back('{exp: e, is_irq: 1'b0, tag: tag});
    mon_go = 1'b1;
    tick(1);
    mon_go = 1'b0;
  endtask

  task automatic chk_irq(logic e, string tag);
    tick(1);
    sb.push_back('{exp: {31'b0, e}, is_irq: 1'b1, tag: tag});
    mon_go = 1'b1;
    tick(1);
    mon_go = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    // R1 / R12 reset values
    chk_reg(MODE, 32'h3, "R1 mode");
    chk_reg(MASK, 32'h3FF, "R1 mask");
    chk_reg(STAT, 32'h0, "R1 status");
    chk_reg(TUP, 32'h2A80, "R1 temp upper");
    chk_reg(OLO, 32'h3200, "R1 ot lower");
    chk_reg(SUPEN, 32'h0, "R1 supen");
    chk_reg(4'd15, 32'h0, "R12 unused addr");
    chk_irq(1'b0, "R1 irq");

    // hysteresis, both alarms
    meas(q87(80));
    chk_reg(STAT, 32'h0, "R3 below upper");
    meas(q87(85));
    chk_reg(STAT, B_T, "R3 equal upper sets");
    chk_irq(1'b0, "R11 masked");
    wr(EN, B_T);
    chk_reg(MASK, 32'h1FF, "R10 enable clears");
    chk_irq(1'b1, "R11 unmasked");
    meas(q87(80));
    wr(STAT, B_T);
    chk_reg(STAT, B_T, "R8 clear while active R4 hold");
    meas(q87(75) - 16'd1);
    chk_reg(STAT, B_T, "R8 sticky after release");
    wr(STAT, B_T);
    chk_reg(STAT, 32'h0, "R8 clear after release");
    chk_irq(1'b0, "R11 no pending");
    meas(q87(80));
    chk_reg(STAT, 32'h0, "R4 no rearm below upper");
    meas(q87(110));
    chk_reg(STAT, B_T | B_O, "R7 both bits");
    wr(DIS, B_T);
    chk_reg(MASK, 32'h3FF, "R10 disable sets");
    chk_irq(1'b0, "R11 all masked");
    wr(EN, B_O);
    chk_irq(1'b1, "R11 ot unmasked");

    // window mode, both alarms (R5, R6)
    wr(MODE, 32'h0);
    meas(q87(90));
    wr(STAT, 32'h3FF);
    chk_reg(STAT, B_T | B_O, "R5 above and below");
    meas(q87(100));
    wr(STAT, 32'h3FF);
    chk_reg(STAT, B_T, "R5 lower bound inside");
    chk_irq(1'b0, "R11 temp masked");
    meas(q87(80));
    wr(STAT, 32'h3FF);
    chk_reg(STAT, B_O, "R5 temp inside ot below");
    chk_irq(1'b1, "R11 ot pending");

    // mixed modes (R6)
    wr(MODE, 32'h1);
    meas(q87(120));
    wr(STAT, 32'h3FF);
    chk_reg(STAT, B_T | B_O, "R6 mode1 high");
    meas(q87(105));
    wr(STAT, 32'h3FF);
    chk_reg(STAT, B_T | B_O, "R6 ot hyst holds");
    wr(MODE, 32'h2);
    meas(q87(105));
    wr(STAT, 32'h3FF);
    chk_reg(STAT, B_T, "R6 ot window inside");
    meas(q87(-10));
    wr(STAT, 32'h3FF);
    chk_reg(STAT, B_O, "R2 signed negative");
    wr(MODE, 32'h3);
    meas(q87(20));
    wr(STAT, 32'h3FF);
    chk_reg(STAT, 32'h0, "R4 ot released");

    // no strobe: reading change ignored (R2)
    tick(1);
    meas_value = q87(120);
    tick(3);
    chk_reg(STAT, 32'h0, "R2 no strobe no change");

    // supply groups (R9)
    wr(SUPEN, 32'h0002_0002);
    chk_reg(SUPEN, 32'h0002_0002, "R9 supen readback");
    tick(1);
    sup_cmp = 20'h0_0001;
    tick(2);
    wr(STAT, 32'h3FF);
    chk_reg(STAT, 32'h0, "R9 disabled channel");
    tick(1);
    sup_cmp = 20'h2_0002;
    tick(2);
    chk_reg(STAT, 32'h011, "R9 groups 0 and 4");
    wr(EN, 32'h001);
    chk_irq(1'b1, "R11 supply pending");
    tick(1);
    sup_cmp = '0;
    tick(1);
    wr(STAT, 32'h01F);
    chk_reg(STAT, 32'h0, "R9 cleared when idle");
    chk_irq(1'b0, "R11 idle");

    tick(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule